// File: doc/BRIEF.md
# Paged Address Translator with Associative Buffer

This block turns a logical address issued by a processor into a physical address. The page number is the upper part of the logical address and the byte-within-page offset is the lower part. A small, fully associative buffer of recent page-to-frame pairs is searched first, with every slot compared at the same time. A match produces the physical address without touching memory.

When the buffer has no match, the block fetches one table word from a flat, single-level page table in memory. The word's address comes from a table base register and the page number. The fetched frame is then installed in the buffer. A slot that is not in use is taken first; when every slot is in use, the least recently used one is replaced.

Two conditions produce a fault instead of an address. The first is a page number that is not below the table length register; no memory read is made in that case. The second is a fetched word whose valid bit is clear. Faulting translations are never buffered. Software programs the base and length registers and can empty the buffer in one cycle. Writing the base register also empties the buffer, which is what a context switch needs.

Top module: `addr_xlate_tlb`

## Requirements
- R1: The physical address equals the frame number joined above the offset, and the low PAGE_BITS bits of the logical address reach `rsp_paddr` unchanged.
- R2: A page held in the buffer is answered with `rsp_hit`=1 and no memory read, and `rsp_valid` rises two clock edges after the request is accepted.
- R3: On a buffer miss the block makes exactly one memory read, at `base + 4*page`. It answers with `rsp_hit`=0 and buffers the entry, so a repeat of the same page hits.
- R4: A page number greater than or equal to the length register faults with no memory read, even if that page is in the buffer. This fault takes two edges, the same as a hit. Writing the length register does not empty the buffer.
- R5: A table word is laid out with the frame number in bits [ADDR_W-1:PAGE_BITS] and the valid bit in bit 0. A word with bit 0 clear gives `rsp_fault`=1 and is not buffered, so a repeat of that page reads memory again.
- R6: When all ENTRIES slots hold pages, a miss replaces the least recently used slot. Both hits and fills count as uses.
- R7: A `flush` pulse, or a write to the base register, empties the buffer. The next access to any page then reads memory, using the base value in force at that time.
- R8: `req_ready` is high only when the block is idle. The response and its fields hold steady while `rsp_ready` is low. `mem_rd_req` stays high with a steady address until `mem_rd_ack`.
- R9: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_rd_req`=0, the buffer is empty, and base and length are zero. Every translation therefore faults until the length is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_laddr | input | ADDR_W | Logical address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | ADDR_W | Physical address (zero on fault) |
| rsp_fault | output | 1 | Range or invalid-entry fault |
| rsp_hit | output | 1 | Answer came from the buffer |
| mem_rd_req | output | 1 | Table word read request, held until acknowledged |
| mem_rd_addr | output | ADDR_W | Byte address of the table word |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | ADDR_W | Table word |
| cfg_base_we | input | 1 | Write the table base (also empties the buffer) |
| cfg_base_data | input | ADDR_W | New table base |
| cfg_len_we | input | 1 | Write the table length |
| cfg_len_data | input | ADDR_W | New table length in entries |
| flush | input | 1 | Empty the buffer |

## Verification
A vector table drives a run of pages, and it separates four outcomes: a first touch that reads memory, a repeat that must hit with no read, a page at the length bound or beyond, and a page whose table word is marked invalid. Repeating the same page under different offsets shows that the offset passes through and the frame comes from the table. Directed sequences cover the rest. Eight distinct pages fill the buffer, then touches and fills in a set order show which slot replacement must pick. A cut in the length register separates the range check from the buffer contents. A flush and a base change force new reads at new addresses. A held `rsp_ready` shows that the response stays steady.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FETCH = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic [ENTRIES-1:0] valid_vec,
  output logic               free_any,
  output logic [IDX_W-1:0]   free_idx
);
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = vld_q[g] && (tag_q[g] == look_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (clear) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_vpn;
        pfn_q[g] <= wr_pfn;
      end
    end
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    hit_pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_idx = IDX_W'(i);
        hit_pfn = pfn_q[i];
      end
    end
  end

  always_comb begin
    free_any = ~&vld_q;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign valid_vec = vld_q;
endmodule

// File: rtl/lru_ages.sv
module lru_ages #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic [IDX_W-1:0]   oldest_idx,
  output logic [ENTRIES-1:0] oldest_oh
);
  // Ages always form a permutation of 0..ENTRIES-1; 0 is newest.
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch) begin
        if (touch_idx == IDX_W'(g)) age_q[g] <= '0;
        else if (age_q[g] < touched_age) age_q[g] <= age_q[g] + 1'b1;
      end
    end
    assign oldest_oh[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (oldest_oh[i]) oldest_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/addr_xlate_tlb.sv
module addr_xlate_tlb
  import xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_hit,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              cfg_base_we,
  input  logic [ADDR_W-1:0] cfg_base_data,
  input  logic              cfg_len_we,
  input  logic [ADDR_W-1:0] cfg_len_data,
  input  logic              flush
);
  localparam int VPN_W = ADDR_W - PAGE_BITS;
  localparam int PFN_W = ADDR_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Arithmetic kept in functions so each rule is written once.
  function automatic logic [VPN_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_BITS];
  endfunction

  function automatic logic [PAGE_BITS-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[PAGE_BITS-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [VPN_W-1:0] p);
    return b + ({{PAGE_BITS{1'b0}}, p} << 2);
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PFN_W-1:0] f,
                                                  input logic [PAGE_BITS-1:0] o);
    return {f, o};
  endfunction

  function automatic logic [PFN_W-1:0] frame_of(input logic [ADDR_W-1:0] w);
    return w[ADDR_W-1:PAGE_BITS];
  endfunction

  function automatic logic beyond_len(input logic [VPN_W-1:0] p,
                                      input logic [ADDR_W-1:0] n);
    return {{PAGE_BITS{1'b0}}, p} >= n;
  endfunction

  xl_state_t state_q, state_d;

  logic [VPN_W-1:0]     lat_vpn;
  logic [PAGE_BITS-1:0] lat_off;
  logic [ADDR_W-1:0]    base_q, len_q;
  logic [ADDR_W-1:0]    paddr_q;
  logic                 fault_q, hit_q;

  // Named internal events for the checker.
  logic ev_accept, ev_hit, ev_miss, ev_range_fault, ev_fill, ev_bad_pte;
  logic pte_ok;

  logic               cam_hit;
  logic [IDX_W-1:0]   cam_hit_idx;
  logic [PFN_W-1:0]   cam_hit_pfn;
  logic [ENTRIES-1:0] cam_valid;
  logic               cam_free_any;
  logic [IDX_W-1:0]   cam_free_idx;
  logic               cam_clear;
  logic [IDX_W-1:0]   fill_idx;

  logic               lru_touch;
  logic [IDX_W-1:0]   lru_idx;
  logic [IDX_W-1:0]   lru_oldest;
  logic [ENTRIES-1:0] victim_oh;

  assign req_ready = (state_q == ST_IDLE);
  assign ev_accept = req_valid && req_ready;

  assign ev_range_fault = (state_q == ST_LOOK) && beyond_len(lat_vpn, len_q);
  assign ev_hit         = (state_q == ST_LOOK) && !beyond_len(lat_vpn, len_q) && cam_hit;
  assign ev_miss        = (state_q == ST_LOOK) && !beyond_len(lat_vpn, len_q) && !cam_hit;
  assign pte_ok         = mem_rd_data[0];
  assign ev_fill        = (state_q == ST_FETCH) && mem_rd_ack && pte_ok;
  assign ev_bad_pte     = (state_q == ST_FETCH) && mem_rd_ack && !pte_ok;

  assign cam_clear = flush || cfg_base_we;
  assign fill_idx  = cam_free_any ? cam_free_idx : lru_oldest;
  assign lru_touch = ev_hit || ev_fill;
  assign lru_idx   = ev_hit ? cam_hit_idx : fill_idx;

  tlb_cam #(
    .ENTRIES(ENTRIES),
    .VPN_W  (VPN_W),
    .PFN_W  (PFN_W)
  ) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cam_clear),
    .look_vpn (lat_vpn),
    .wr_en    (ev_fill),
    .wr_idx   (fill_idx),
    .wr_vpn   (lat_vpn),
    .wr_pfn   (frame_of(mem_rd_data)),
    .hit      (cam_hit),
    .hit_idx  (cam_hit_idx),
    .hit_pfn  (cam_hit_pfn),
    .valid_vec(cam_valid),
    .free_any (cam_free_any),
    .free_idx (cam_free_idx)
  );

  lru_ages #(
    .ENTRIES(ENTRIES)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (lru_touch),
    .touch_idx (lru_idx),
    .oldest_idx(lru_oldest),
    .oldest_oh (victim_oh)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ev_accept) state_d = ST_LOOK;
      ST_LOOK:  state_d = ev_miss ? ST_FETCH : ST_RESP;
      ST_FETCH: if (mem_rd_ack) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lat_vpn <= '0;
      lat_off <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        lat_vpn <= page_of(req_laddr);
        lat_off <= offset_of(req_laddr);
      end
      if (ev_range_fault) begin
        paddr_q <= '0;
        fault_q <= 1'b1;
        hit_q   <= 1'b0;
      end else if (ev_hit) begin
        paddr_q <= join_addr(cam_hit_pfn, lat_off);
        fault_q <= 1'b0;
        hit_q   <= 1'b1;
      end else if (ev_fill) begin
        paddr_q <= join_addr(frame_of(mem_rd_data), lat_off);
        fault_q <= 1'b0;
        hit_q   <= 1'b0;
      end else if (ev_bad_pte) begin
        paddr_q <= '0;
        fault_q <= 1'b1;
        hit_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (cfg_base_we) base_q <= cfg_base_data;
      if (cfg_len_we)  len_q  <= cfg_len_data;
    end
  end

  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_paddr   = paddr_q;
  assign rsp_fault   = fault_q;
  assign rsp_hit     = hit_q;
  assign mem_rd_req  = (state_q == ST_FETCH);
  assign mem_rd_addr = entry_addr(base_q, lat_vpn);
endmodule

// File: rtl/addr_xlate_tlb_chk.sv
module addr_xlate_tlb_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [ADDR_W-1:0]  rsp_paddr,
  input logic               rsp_fault,
  input logic               rsp_hit,
  input logic               mem_rd_req,
  input logic               mem_rd_ack,
  input logic [ADDR_W-1:0]  mem_rd_addr,
  input logic               flush,
  input logic               cfg_base_we,
  input logic               ev_hit,
  input logic               ev_miss,
  input logic               ev_range_fault,
  input logic               ev_bad_pte,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] victim_oh,
  input logic [PAGE_BITS-1:0] lat_off
);
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[PAGE_BITS-1:0] == lat_off);

  p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> rsp_valid && rsp_hit && !mem_rd_req);

  p_miss_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> mem_rd_req);

  p_range_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range_fault |=> rsp_valid && rsp_fault && !mem_rd_req);

  p_bad_pte_kept_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_pte && !flush && !cfg_base_we |=> $stable(valid_vec) && rsp_fault);

  p_one_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim_oh) == 1);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush || cfg_base_we |=> valid_vec == '0);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                && $stable(rsp_hit));

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid || mem_rd_req |-> !req_ready);
endmodule

bind addr_xlate_tlb addr_xlate_tlb_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_BITS(PAGE_BITS),
  .ENTRIES  (ENTRIES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .rsp_hit       (rsp_hit),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_ack    (mem_rd_ack),
  .mem_rd_addr   (mem_rd_addr),
  .flush         (flush),
  .cfg_base_we   (cfg_base_we),
  .ev_hit        (ev_hit),
  .ev_miss       (ev_miss),
  .ev_range_fault(ev_range_fault),
  .ev_bad_pte    (ev_bad_pte),
  .valid_vec     (cam_valid),
  .victim_oh     (victim_oh),
  .lat_off       (lat_off)
);

// File: tb/sim_addr_xlate_tlb.sv
`timescale 1ns/1ps
module sim_addr_xlate_tlb;
  localparam int AW = 32;
  localparam int PB = 12;
  localparam int NV = 12;
  localparam int K_HIT = 0, K_MISS = 1, K_RANGE = 2, K_BAD = 3;

  localparam logic [AW-1:0] V_ADDR [NV] = '{
    32'h0000_3ABC, 32'h0000_3001, 32'h0000_5FFF, 32'h0000_E123,
    32'h0000_F000, 32'h0001_0000, 32'h0000_7004, 32'h0000_7008,
    32'h0000_5000, 32'h0000_E7FF, 32'hFFFF_F123, 32'h0000_3FFF };
  localparam int V_KIND [NV] = '{
    K_MISS, K_HIT, K_MISS, K_MISS, K_RANGE, K_RANGE,
    K_BAD, K_BAD, K_HIT, K_HIT, K_RANGE, K_HIT };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_laddr = '0;
  logic req_ready, rsp_valid, rsp_fault, rsp_hit, mem_rd_req;
  logic [AW-1:0] rsp_paddr, mem_rd_addr;
  logic mem_rd_ack = 1'b0;
  logic [AW-1:0] mem_rd_data = '0;
  logic cfg_base_we = 1'b0, cfg_len_we = 1'b0, flush = 1'b0;
  logic [AW-1:0] cfg_base_data = '0, cfg_len_data = '0;

  int n_chk = 0, n_fail = 0, n_reads = 0, mem_wait = 0;
  logic [AW-1:0] last_raddr = '0;
  logic [AW-1:0] cur_base = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_xlate_tlb u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_hit(rsp_hit),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .cfg_base_we(cfg_base_we), .cfg_base_data(cfg_base_data),
    .cfg_len_we(cfg_len_we), .cfg_len_data(cfg_len_data), .flush(flush));

  // Table model: frame derived from the word address; valid unless word index low bits are 7.
  function automatic logic [AW-PB-1:0] tbl_frame(input logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = (a >> 2) ^ 32'h0003_C5A0;
    return t[AW-PB-1:0];
  endfunction
  function automatic logic tbl_ok(input logic [AW-1:0] a);
    return a[4:2] != 3'b111;
  endfunction
  function automatic logic [AW-1:0] word_at(input logic [AW-1:0] laddr);
    return cur_base + ((laddr >> PB) << 2);
  endfunction
  function automatic logic [AW-1:0] expect_pa(input logic [AW-1:0] laddr);
    return {tbl_frame(word_at(laddr)), laddr[PB-1:0]};
  endfunction

  // Memory responder, two cycles of wait, acknowledge for one edge.
  always @(negedge clk) begin
    if (mem_rd_ack) begin
      mem_rd_ack = 1'b0;
    end else if (mem_rd_req) begin
      if (mem_wait == 2) begin
        mem_wait = 0;
        mem_rd_ack = 1'b1;
        mem_rd_data = {tbl_frame(mem_rd_addr), 11'b0, tbl_ok(mem_rd_addr)};
        n_reads++;
        last_raddr = mem_rd_addr;
      end else begin
        mem_wait++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int which, input logic [AW-1:0] v);
    @(negedge clk);
    if (which == 0) begin cfg_base_we = 1'b1; cfg_base_data = v; cur_base = v; end
    else if (which == 1) begin cfg_len_we = 1'b1; cfg_len_data = v; end
    else flush = 1'b1;
    @(negedge clk);
    cfg_base_we = 1'b0; cfg_len_we = 1'b0; flush = 1'b0;
  endtask

  task automatic xlate(input logic [AW-1:0] la, input int hold,
                       output logic [AW-1:0] pa, output logic f, output logic h,
                       output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid) begin @(negedge clk); cyc++; end
    pa = rsp_paddr; f = rsp_fault; h = rsp_hit;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == pa && rsp_fault == f && !req_ready,
            "R8 response hold", {31'b0, rsp_valid, rsp_paddr}, {32'h1, pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic expect_kind(input logic [AW-1:0] la, input int kind, input string tag);
    logic [AW-1:0] pa; logic f, h; int cyc, r0;
    r0 = n_reads;
    xlate(la, 0, pa, f, h, cyc);
    case (kind)
      K_HIT: begin
        check(!f && h && pa == expect_pa(la), {tag, " R2 hit paddr (R1)"}, pa, expect_pa(la));
        check(n_reads == r0 && cyc == 2, {tag, " R2 no read, two edges"}, cyc, 2);
      end
      K_MISS: begin
        check(!f && !h && pa == expect_pa(la), {tag, " R3 miss paddr (R1)"}, pa, expect_pa(la));
        check(n_reads == r0 + 1 && last_raddr == word_at(la), {tag, " R3 one read at entry"},
              last_raddr, word_at(la));
      end
      K_RANGE: begin
        check(f && pa == '0, {tag, " R4 range fault"}, {f, pa}, {1'b1, 32'h0});
        check(n_reads == r0 && cyc == 2, {tag, " R4 no read"}, n_reads - r0, 0);
      end
      default: begin
        check(f && !h, {tag, " R5 invalid entry fault"}, f, 1);
        check(n_reads == r0 + 1, {tag, " R5 read made"}, n_reads - r0, 1);
      end
    endcase
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pa; logic f, h; int cyc, r0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(req_ready && !rsp_valid && !mem_rd_req, "R9 reset outputs",
          {req_ready, rsp_valid, mem_rd_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: zero length, so everything faults with no read
    r0 = n_reads;
    xlate(32'h0000_1234, 0, pa, f, h, cyc);
    check(f && n_reads == r0, "R9 zero length faults", {f, 31'(n_reads - r0)}, 32'h8000_0000);

    cfg_write(0, 32'h0010_0000);
    cfg_write(1, 32'd15);

    // Vector table walk
    for (int i = 0; i < NV; i++) expect_kind(V_ADDR[i], V_KIND[i], $sformatf("vec%0d", i));

    // R8: response held while consumer stalls
    xlate(32'h0000_5ABC, 3, pa, f, h, cyc);
    check(pa == expect_pa(32'h0000_5ABC) && h, "R8 held response value", pa,
          expect_pa(32'h0000_5ABC));

    // R4: buffered page beyond a shortened length; length write keeps the buffer
    cfg_write(1, 32'd4);
    expect_kind(32'h0000_5010, K_RANGE, "cut");
    cfg_write(1, 32'd15);
    expect_kind(32'h0000_5020, K_HIT, "restored R4");

    // R7: flush input empties the buffer
    cfg_write(2, '0);
    expect_kind(32'h0000_3333, K_MISS, "after flush R7");

    // R6: LRU replacement over a full buffer
    cfg_write(2, '0);
    expect_kind(32'h0000_0000, K_MISS, "fill0");
    expect_kind(32'h0000_1000, K_MISS, "fill1");
    expect_kind(32'h0000_2000, K_MISS, "fill2");
    expect_kind(32'h0000_3000, K_MISS, "fill3");
    expect_kind(32'h0000_4000, K_MISS, "fill4");
    expect_kind(32'h0000_5000, K_MISS, "fill5");
    expect_kind(32'h0000_6000, K_MISS, "fill6");
    expect_kind(32'h0000_8000, K_MISS, "fill8");
    expect_kind(32'h0000_0100, K_HIT, "touch0");
    expect_kind(32'h0000_9000, K_MISS, "R6 evicts page1");
    expect_kind(32'h0000_1100, K_MISS, "R6 page1 gone");
    expect_kind(32'h0000_0200, K_HIT, "R6 page0 kept");
    expect_kind(32'h0000_2200, K_MISS, "R6 page2 next out");
    expect_kind(32'h0000_8200, K_HIT, "R6 page8 kept");

    // R7: base write flushes and moves the table
    cfg_write(0, 32'h0020_0000);
    expect_kind(32'h0000_5444, K_MISS, "new base R7");
    expect_kind(32'h0000_5555, K_HIT, "new base again");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule